// File: doc/BRIEF.md
# Byte-Steered Converter Register Port

This block is the bus-facing register logic of a 12-bit sampling converter that hangs on a parallel host bus of either 8 or 16 bits. The host selects the block with an active-low select line. It then reads or writes with active-low strobes, and a byte-lane line picks the upper or lower half of the transfer. Writes always go one byte at a time. The low half is parked in a staging register, and the addressed register changes only when the matching upper half arrives. Reads are asymmetric. The conversion result and the control register come out whole, all 12 bits in one access, when the byte-lane line is low. The two calibration words always need a low-byte read and then a high-byte read.

A rising edge on the convert-start input makes the busy flag go high for a fixed number of clock cycles. When that window closes, the value on a result input is captured. Setting the calibrate bit in the control register makes busy go high for a longer, separately set window. The control register also picks which register the next read returns. It chooses the output coding too: plain binary, or two's complement formed by flipping the top bit. The tri-state bus is shown as a read-data vector plus a per-bit output-enable vector. A pad ring would merge these with the incoming write byte.

Top module: `adc_regif`

## Requirements
- R1: Strobes have effect only while `cs_n` is low. A byte written with `cs_n` high leaves every register unchanged.
- R2: A write with `hb_sel` low stores the byte in a staging register and changes no visible register. The next write with `hb_sel` high updates the target register from both bytes. A high-byte write with no staged low byte is ignored.
- R3: The assembled write word is {high byte, low byte}. Bits 15:12 select the target: 0 = control, 1 = gain calibration, 2 = offset calibration. Any other code is ignored. Bits 11:0 are the new register contents.
- R4: Control register fields: bit 0 selects bipolar coding. Bit 1 starts calibration and always reads back as 0. Bits 3:2 choose what a read returns: 00 result, 01 control, 10 gain, 11 offset. Bits 11:4 are stored and read back unchanged.
- R5: A read with `hb_sel` low of the result or of the control register drives all 12 bits on `bus_rdata[11:0]`, with `bus_oe` = 0xFFF.
- R6: A read with `hb_sel` high returns bits 11:8 of the selected register on `bus_rdata[3:0]`. Bits 7:4 are zero and `bus_oe` = 0x0FF.
- R7: A read with `hb_sel` low of either calibration register returns its bits 7:0 on `bus_rdata[7:0]`, with `bus_oe` = 0x0FF.
- R8: `bus_oe` is all zero unless `cs_n` and `rd_n` are both low. Bits 11:9 are enabled only in a full 12-bit read.
- R9: The result reads as straight binary in unipolar mode. In bipolar mode it reads with its most significant bit inverted.
- R10: A rising edge of `conv_start` while idle raises `busy` from the next cycle for exactly CONV_CYCLES cycles. `result_in` is captured at the clock edge that ends the window.
- R11: Committing a control word with bit 1 set while idle raises `busy` for exactly CAL_CYCLES cycles.
- R12: `conv_start` edges while `busy` is high are ignored. The busy window keeps its length and the stored result is unchanged.
- R13: After reset `busy` is low, `bus_oe` is zero and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low device select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| hb_sel | input | 1 | Byte lane: 1 = upper byte, 0 = lower byte or full read |
| bus_wdata | input | 8 | Write byte from the bus lines 7:0 |
| bus_rdata | output | 12 | Read data toward the bus lines |
| bus_oe | output | 12 | Per-line output enable; 0 means high impedance |
| conv_start | input | 1 | Convert request, acts on its rising edge |
| result_in | input | 12 | Synthetic conversion value captured at the end of a conversion |
| busy | output | 1 | High while a conversion or calibration runs |

## Verification
The properties assume that read and write strobes are never low at the same time. They also assume `conv_start` stays low until two cycles after reset release, because the internal reset synchronizer is still holding state in that span. The stimulus drives each access as one full strobe cycle followed by one idle cycle. All inputs change on the falling clock edge, and `result_in` is held steady across each conversion window. The busy-window property counts high cycles in the checker. It only requires that each window ends at one of the two configured lengths, so convert edges sent into a running calibration fall within what it assumes.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;

  localparam int DATA_W = 12;
  localparam int BYTE_W = 8;
  localparam int TGT_W  = 4;

  typedef enum logic [1:0] {
    RSEL_RESULT = 2'd0,
    RSEL_CTRL   = 2'd1,
    RSEL_GAIN   = 2'd2,
    RSEL_OFFS   = 2'd3
  } rsel_e;

  typedef struct packed {
    logic [DATA_W-5:0] spare;
    rsel_e             rsel;
    logic              cal_go;
    logic              bipolar;
  } ctrl_t;

  localparam logic [TGT_W-1:0] TGT_CTRL = 4'd0;
  localparam logic [TGT_W-1:0] TGT_GAIN = 4'd1;
  localparam logic [TGT_W-1:0] TGT_OFFS = 4'd2;

endpackage

// File: rtl/adc_bus_dec.sv
module adc_bus_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_act,
  output logic wr_go
);

  logic wr_act;
  logic wr_act_q;

  assign rd_act = ~cs_n & ~rd_n;
  assign wr_act = ~cs_n & ~wr_n;
  assign wr_go  = wr_act & ~wr_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_act_q <= 1'b0;
    else        wr_act_q <= wr_act;
  end

endmodule

// File: rtl/adc_wr_asm.sv
module adc_wr_asm
  import adc_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic              hb_sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic              commit,
  output logic [TGT_W-1:0]  commit_tgt,
  output logic [DATA_W-1:0] commit_data
);

  logic [BYTE_W-1:0] lo_q, lo_d;
  logic              vld_q, vld_d;
  logic              lo_en;

  always_comb begin
    lo_d   = lo_q;
    vld_d  = vld_q;
    lo_en  = 1'b0;
    commit = 1'b0;
    if (wr_go) begin
      if (!hb_sel) begin
        lo_d  = wdata;
        lo_en = 1'b1;
        vld_d = 1'b1;
      end else if (vld_q) begin
        commit = 1'b1;
        vld_d  = 1'b0;
      end
    end
  end

  assign commit_tgt  = wdata[BYTE_W-1:BYTE_W-TGT_W];
  assign commit_data = {wdata[DATA_W-BYTE_W-1:0], lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      if (lo_en) lo_q <= lo_d;
      vld_q <= vld_d;
    end
  end

endmodule

// File: rtl/adc_busy_ctr.sv
module adc_busy_ctr
  import adc_regif_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 20,
  parameter int unsigned CAL_CYCLES  = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic              cal_req,
  input  logic [DATA_W-1:0] result_in,
  output logic              busy,
  output logic [DATA_W-1:0] result_q
);

  localparam int unsigned MAXC = (CAL_CYCLES > CONV_CYCLES) ? CAL_CYCLES : CONV_CYCLES;
  localparam int          CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          conv_q;
  logic          run_q, run_d;
  logic          rise, cap;

  assign rise = conv_start & ~conv_q;
  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    cap   = 1'b0;
    if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        cap   = run_q;
        run_d = 1'b0;
      end
    end else if (cal_req) begin
      cnt_d = CW'(CAL_CYCLES);
      run_d = 1'b0;
    end else if (rise) begin
      cnt_d = CW'(CONV_CYCLES);
      run_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      conv_q   <= 1'b0;
      run_q    <= 1'b0;
      result_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      conv_q <= conv_start;
      run_q  <= run_d;
      if (cap) result_q <= result_in;
    end
  end

endmodule

// File: rtl/adc_regif.sv
module adc_regif
  import adc_regif_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 20,
  parameter int unsigned CAL_CYCLES  = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              hb_sel,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] bus_oe,
  input  logic              conv_start,
  input  logic [DATA_W-1:0] result_in,
  output logic              busy
);

  localparam int HI_W = DATA_W - BYTE_W;
  localparam logic [DATA_W-1:0] OE_FULL = '1;
  localparam logic [DATA_W-1:0] OE_BYTE = {{HI_W{1'b0}}, {BYTE_W{1'b1}}};

  // reset: asserted asynchronously, removed on the clock
  logic [1:0] rsync_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  logic              rd_act, wr_go;
  logic              commit;
  logic [TGT_W-1:0]  commit_tgt;
  logic [DATA_W-1:0] commit_data;
  logic [DATA_W-1:0] result_q;
  logic              cal_req;

  adc_bus_dec u_dec (
    .clk(clk), .rst_n(arst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .rd_act(rd_act), .wr_go(wr_go)
  );

  adc_wr_asm u_wr (
    .clk(clk), .rst_n(arst_n), .wr_go(wr_go), .hb_sel(hb_sel), .wdata(bus_wdata),
    .commit(commit), .commit_tgt(commit_tgt), .commit_data(commit_data)
  );

  adc_busy_ctr #(.CONV_CYCLES(CONV_CYCLES), .CAL_CYCLES(CAL_CYCLES)) u_busy (
    .clk(clk), .rst_n(arst_n), .conv_start(conv_start), .cal_req(cal_req),
    .result_in(result_in), .busy(busy), .result_q(result_q)
  );

  // register bank
  ctrl_t             ctrl_q, ctrl_d;
  logic [DATA_W-1:0] gain_q, offs_q;
  logic              ctrl_en, gain_en, offs_en;

  always_comb begin
    ctrl_d        = ctrl_t'(commit_data);
    ctrl_d.cal_go = 1'b0;
    ctrl_en       = commit && (commit_tgt == TGT_CTRL);
    gain_en       = commit && (commit_tgt == TGT_GAIN);
    offs_en       = commit && (commit_tgt == TGT_OFFS);
  end

  assign cal_req = ctrl_en & commit_data[1];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ctrl_q <= '0;
      gain_q <= '0;
      offs_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (gain_en) gain_q <= commit_data;
      if (offs_en) offs_q <= commit_data;
    end
  end

  // read steering
  logic [DATA_W-1:0] fmt_res, sel_val;
  logic              whole;

  assign fmt_res = result_q ^ {ctrl_q.bipolar, {(DATA_W-1){1'b0}}};

  always_comb begin
    unique case (ctrl_q.rsel)
      RSEL_RESULT: begin sel_val = fmt_res;        whole = 1'b1; end
      RSEL_CTRL:   begin sel_val = DATA_W'(ctrl_q); whole = 1'b1; end
      RSEL_GAIN:   begin sel_val = gain_q;          whole = 1'b0; end
      default:     begin sel_val = offs_q;          whole = 1'b0; end
    endcase
    bus_rdata = '0;
    bus_oe    = '0;
    if (rd_act) begin
      if (hb_sel) begin
        bus_rdata = {{BYTE_W{1'b0}}, sel_val[DATA_W-1:BYTE_W]};
        bus_oe    = OE_BYTE;
      end else if (whole) begin
        bus_rdata = sel_val;
        bus_oe    = OE_FULL;
      end else begin
        bus_rdata = {{HI_W{1'b0}}, sel_val[BYTE_W-1:0]};
        bus_oe    = OE_BYTE;
      end
    end
  end

endmodule

// File: rtl/adc_regif_chk.sv
module adc_regif_chk #(
  parameter int unsigned CONV_CYCLES = 20,
  parameter int unsigned CAL_CYCLES  = 60
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        rd_n,
  input logic        hb_sel,
  input logic [11:0] bus_oe,
  input logic        conv_start,
  input logic        busy
);

  logic [31:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 32'd1;
    else           run_len <= '0;
  end

  // R8: lines float unless a read is under way
  a_r8_float_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_n && !rd_n) |-> (bus_oe == 12'h000));

  // R8: output-only lines enabled only in a full low-lane read
  a_r8_upper_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe[11:9] != 3'b000) |-> (!cs_n && !rd_n && !hb_sel));

  // R6: an upper-lane read enables exactly the lower eight lines
  a_r6_hi_lane_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && hb_sel) |-> (bus_oe == 12'h0FF));

  // R10: a convert edge while idle raises busy
  a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(conv_start) && !busy) |=> busy);

  // R10 / R11 / R12: every busy window has one of the configured lengths
  a_r12_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == CONV_CYCLES || run_len == CAL_CYCLES));

endmodule

bind adc_regif adc_regif_chk #(.CONV_CYCLES(CONV_CYCLES), .CAL_CYCLES(CAL_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .hb_sel(hb_sel),
  .bus_oe(bus_oe), .conv_start(conv_start), .busy(busy)
);

// File: tb/tb_adc_regif.sv
module tb_adc_regif;

  localparam int CLK_PERIOD = 10;
  localparam int CONV_N = 20;
  localparam int CAL_N  = 60;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, rd_n, wr_n, hb_sel, conv_start;
  logic [7:0]  bus_wdata;
  logic [11:0] result_in, bus_rdata, bus_oe;
  logic        busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_regif #(.CONV_CYCLES(CONV_N), .CAL_CYCLES(CAL_N)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .hb_sel(hb_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_oe(bus_oe), .conv_start(conv_start), .result_in(result_in), .busy(busy)
  );

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    string       req;
    logic [11:0] d;
    logic [11:0] oe;
  } exp_t;
  exp_t sb_q[$];
  event smp;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected read items and compares them with the bus
  initial begin
    forever begin
      @(smp);
      if (sb_q.size() == 0) begin
        chk("scoreboard-empty", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.req, " data"}, {20'd0, bus_rdata}, {20'd0, e.d});
        chk({e.req, " oe"},   {20'd0, bus_oe},    {20'd0, e.oe});
      end
    end
  end

  task automatic wr_byte(input logic cs, input logic h, input logic [7:0] b);
    @(negedge clk);
    cs_n = cs; wr_n = 1'b0; hb_sel = h; bus_wdata = b;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic wr_word(input logic [3:0] tgt, input logic [11:0] pay);
    wr_byte(1'b0, 1'b0, pay[7:0]);
    wr_byte(1'b0, 1'b1, {tgt, pay[11:8]});
  endtask

  task automatic rd_chk(input string req, input logic h, input logic [11:0] ed, input logic [11:0] eo);
    exp_t e;
    e.req = req; e.d = ed; e.oe = eo;
    sb_q.push_back(e);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; hb_sel = h;
    #(CLK_PERIOD/4);
    -> smp;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic conv_pulse();
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
  endtask

  task automatic busy_len(output int n, input int pulse_at);
    n = 0;
    while (busy && n < 1000) begin
      conv_start = (n == pulse_at);
      n++;
      @(negedge clk);
    end
    conv_start = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; hb_sel = 1'b0;
    bus_wdata = '0; conv_start = 1'b0; result_in = 12'h8F3;
    repeat (3) @(negedge clk);
    chk("R13 busy in reset", {31'd0, busy}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13 busy after reset", {31'd0, busy}, 0);
    chk("R13 oe after reset", {20'd0, bus_oe}, 0);
    rd_chk("R13 result zero", 1'b0, 12'h000, 12'hFFF);

    // control readback, full and upper lane
    wr_word(4'h0, 12'hA54);
    rd_chk("R5 R4 control full read", 1'b0, 12'hA54, 12'hFFF);
    rd_chk("R6 control upper lane", 1'b1, 12'h00A, 12'h0FF);

    // staging
    wr_byte(1'b0, 1'b0, 8'h44);
    rd_chk("R2 low byte alone no effect", 1'b0, 12'hA54, 12'hFFF);
    wr_byte(1'b0, 1'b1, 8'h0B);
    rd_chk("R2 high byte commits", 1'b0, 12'hB44, 12'hFFF);
    wr_byte(1'b0, 1'b1, 8'h0C);
    rd_chk("R2 orphan high byte ignored", 1'b0, 12'hB44, 12'hFFF);

    // deselected writes
    wr_byte(1'b1, 1'b0, 8'h00);
    wr_byte(1'b1, 1'b1, 8'h00);
    rd_chk("R1 write while deselected ignored", 1'b0, 12'hB44, 12'hFFF);

    // unused target code
    wr_word(4'h7, 12'h000);
    rd_chk("R3 unknown target ignored", 1'b0, 12'hB44, 12'hFFF);

    // idle float
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #(CLK_PERIOD/4);
    chk("R8 deselected read floats", {20'd0, bus_oe}, 0);
    @(negedge clk); rd_n = 1'b1; cs_n = 1'b0; #(CLK_PERIOD/4);
    chk("R8 selected without strobe floats", {20'd0, bus_oe}, 0);
    @(negedge clk); cs_n = 1'b1;

    // conversion
    wr_word(4'h0, 12'h000);
    conv_pulse();
    busy_len(n, -1);
    chk("R10 conversion busy length", n, CONV_N);
    rd_chk("R10 R9 unipolar result", 1'b0, 12'h8F3, 12'hFFF);
    rd_chk("R6 result upper lane", 1'b1, 12'h008, 12'h0FF);
    wr_word(4'h0, 12'h001);
    rd_chk("R9 bipolar result", 1'b0, 12'h0F3, 12'hFFF);
    rd_chk("R9 bipolar upper lane", 1'b1, 12'h000, 12'h0FF);

    // calibration registers
    wr_word(4'h1, 12'h3C7);
    wr_word(4'h0, 12'h008);
    rd_chk("R7 gain low byte", 1'b0, 12'h0C7, 12'h0FF);
    rd_chk("R6 gain high byte", 1'b1, 12'h003, 12'h0FF);
    wr_word(4'h2, 12'h5E1);
    wr_word(4'h0, 12'h00C);
    rd_chk("R7 offset low byte", 1'b0, 12'h0E1, 12'h0FF);
    rd_chk("R6 offset high byte", 1'b1, 12'h005, 12'h0FF);

    // calibration with a convert edge inside it
    result_in = 12'h123;
    wr_word(4'h0, 12'h002);
    busy_len(n, 10);
    chk("R11 R12 calibration busy length", n, CAL_N);
    rd_chk("R12 result untouched by ignored edge", 1'b0, 12'h8F3, 12'hFFF);
    wr_word(4'h0, 12'h006);
    busy_len(n, -1);
    chk("R11 second calibration length", n, CAL_N);
    rd_chk("R4 calibrate bit reads zero", 1'b0, 12'h004, 12'hFFF);

    // fresh conversion picks up new value
    conv_pulse();
    busy_len(n, -1);
    chk("R10 second conversion length", n, CONV_N);
    wr_word(4'h0, 12'h000);
    rd_chk("R10 new result captured", 1'b0, 12'h123, 12'hFFF);

    @(negedge clk);
    chk("scoreboard drained", sb_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule